// File: doc/BRIEF.md
# USB Host Controller Port Status Register Bank

This block holds the per-port status and control words of a USB host controller. Each root-hub port has its own 16-byte window in the operational register space. The windows start after the controller-wide registers, at byte offset 0x400, one port after another. Software reaches the bank over a 32-bit little-endian register bus. Reads return data one cycle after the request.

Only the first word of each window is implemented, and it is the port status/control word. Change flags are cleared by writing 1 to them. A port reset is started by writing 1 to the reset bit. That write sends a one-cycle reset pulse to the attached device model, and it reports reset-complete and port-enabled straight away. Device attach and detach events come in on per-port strobes.

Ports are numbered with the USB2-capable ports first. The USB3-only ports follow them. A static per-port flag tells the rest of the controller which ports are SuperSpeed.

Top module: `usbhc_port_bank`

## Requirements
- R1: After reset every port's status word reads 0x0000_0200: port power (bit 9) is 1 and all other bits are 0.
- R2: Port N's status word is at byte address PORT_BASE + 0x10*N, with PORT_BASE = 0x400 by default. Each port's word is independent of the others.
- R3: The words at offsets 0x4, 0x8 and 0xC of a port window, and any unaligned offset, read as zero. Writes to them change no port state.
- R4: Addresses below PORT_BASE, and addresses at or beyond the window of the last configured port, read as zero. Writes to them change no port state.
- R5: Only 4-byte accesses (bus_size = 4) are accepted. An access of any other size reads as zero, and a write of any other size is ignored.
- R6: An attach strobe sets current-connect (bit 0) and connect-change (bit 17).
- R7: A detach strobe clears current-connect and enabled (bit 1) and sets connect-change. If attach and detach arrive in the same cycle, detach wins. A strobe in the same cycle as a write is applied after the write's effect.
- R8: Writing 1 to any change bit clears it. The change bits are connect (17), enable (18), warm-reset (19), over-current (20), reset (21), link-state (22) and config-error (23). Writing 0 leaves a change bit unchanged.
- R9: Writing 1 to reset (bit 4) raises dev_reset_pulse[N] for exactly the one cycle after the write edge. The same write sets enabled (bit 1) and reset-change (bit 21). Bit 4 always reads 0.
- R10: bus_rdata is registered. It shows the addressed word from the edge that samples bus_rd and holds until the next read. A read in the same cycle as a write returns the value from before the write.
- R11: port_super_speed[N] is 1 exactly for ports N >= NUM_USB2 (the USB3-only ports) and 0 for USB2-capable ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address within the operational region |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| attach_stb | input | NUM_PORTS | Per-port device-attached strobe |
| detach_stb | input | NUM_PORTS | Per-port device-detached strobe |
| dev_reset_pulse | output | NUM_PORTS | One-cycle reset to each port's device |
| port_super_speed | output | NUM_PORTS | 1 for USB3-only ports |

## Verification
The bench goes after the address corners: the secondary words of a window, unaligned offsets, the first address past the last port, addresses just below the port area, and sizes other than four bytes. A faulty decoder would alias one of these onto a status word, and the write would then corrupt a neighbour port. It also mixes clears with attach and detach strobes in the same cycle. A design that ordered these the wrong way would lose a connect-change or leave a detached port enabled. Reset writes are checked for a pulse that lasts exactly one cycle and for a reset bit that reads back as zero. A stretched pulse or a sticky bit shows up in both places.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;

    localparam int B_CCS = 0;
    localparam int B_PED = 1;
    localparam int B_OCA = 3;
    localparam int B_PR  = 4;
    localparam int B_PP  = 9;
    localparam int B_CHG_LO = 17;
    localparam int N_CHG = 7;
    localparam int CHG_RST_IDX = 4;   // reset-change, bit 21
    localparam int CHG_CON_IDX = 0;   // connect-change, bit 17

    typedef struct packed {
        logic             ccs;
        logic             ped;
        logic             oca;
        logic             pp;
        logic [N_CHG-1:0] chg;
        logic             rst_pulse;
    } port_state_t;

    function automatic logic [31:0] pack_word(port_state_t s);
        logic [31:0] w;
        w = '0;
        w[B_CCS] = s.ccs;
        w[B_PED] = s.ped;
        w[B_OCA] = s.oca;
        w[B_PP]  = s.pp;
        w[B_CHG_LO +: N_CHG] = s.chg;
        return w;
    endfunction

endpackage

// File: rtl/usbhc_addr_dec.sv
module usbhc_addr_dec #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] PORT_BASE = 12'h400,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [2:0]           size,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_PORTS-1:0] sel
);
    localparam int WIN_W = ADDR_W - 4;

    logic [ADDR_W-1:0] offs;
    logic [WIN_W-1:0]  win;
    logic              in_range;
    logic              port_ok;
    logic              word_ok;
    logic              size_ok;

    always_comb begin
        offs     = addr - PORT_BASE;
        win      = offs[ADDR_W-1:4];
        in_range = (addr >= PORT_BASE);
        port_ok  = (win < WIN_W'(NUM_PORTS));
        word_ok  = (offs[3:0] == 4'h0);
        size_ok  = (size == 3'd4);
        hit      = in_range && port_ok && word_ok && size_ok;
        idx      = win[IDX_W-1:0];
    end

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_sel
        assign sel[gi] = hit && (win == WIN_W'(gi));
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R2

    AST_SEL_NEEDS_SIZE4: assert property (@(posedge clk) disable iff (!rst_n)
        (size != 3'd4) |-> (sel == '0)); // R5

endmodule

// File: rtl/usbhc_port_reg.sv
module usbhc_port_reg
    import usbhc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [31:0] wdata,
    input  logic        attach,
    input  logic        detach,
    output logic [31:0] word,
    output logic        dev_reset
);
    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.rst_pulse = 1'b0;
        if (wr_sel) begin
            st_d.chg = st_q.chg & ~wdata[B_CHG_LO +: N_CHG];
            if (wdata[B_PR]) begin
                st_d.ped = 1'b1;
                st_d.chg[CHG_RST_IDX] = 1'b1;
                st_d.rst_pulse = 1'b1;
            end
        end
        if (detach) begin
            st_d.ccs = 1'b0;
            st_d.ped = 1'b0;
            st_d.chg[CHG_CON_IDX] = 1'b1;
        end else if (attach) begin
            st_d.ccs = 1'b1;
            st_d.chg[CHG_CON_IDX] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pp <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word      = pack_word(st_q);
    assign dev_reset = st_q.rst_pulse;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[B_CHG_LO + 2] && !wdata[B_PR]) |=> !word[B_CHG_LO + 2]); // R8

    AST_ATTACH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (attach && !detach) |=> (word[B_CCS] && word[B_CHG_LO])); // R6

    AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        detach |=> (!word[B_CCS] && !word[B_PED] && word[B_CHG_LO])); // R7

    AST_RESET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[B_PR] && !detach) |=> (word[B_PED] && word[B_CHG_LO + CHG_RST_IDX] && dev_reset)); // R9

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_reset && !$past(wr_sel && wdata[B_PR])) |-> 1'b0); // R9

endmodule

// File: rtl/usbhc_port_bank.sv
module usbhc_port_bank #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_USB2  = 2,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] PORT_BASE = 12'h400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [2:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PORTS-1:0] attach_stb,
    input  logic [NUM_PORTS-1:0] detach_stb,
    output logic [NUM_PORTS-1:0] dev_reset_pulse,
    output logic [NUM_PORTS-1:0] port_super_speed
);
    import usbhc_pkg::*;

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic [31:0] rdata;
    } bank_state_t;

    bank_state_t bk_d, bk_q;

    logic                 hit;
    logic [IDX_W-1:0]     idx;
    logic [NUM_PORTS-1:0] sel;
    logic [31:0]          words [NUM_PORTS];

    usbhc_addr_dec #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .PORT_BASE (PORT_BASE)
    ) dec_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .size  (bus_size),
        .hit   (hit),
        .idx   (idx),
        .sel   (sel)
    );

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
        usbhc_port_reg port_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (bus_wr && sel[gi]),
            .wdata     (bus_wdata),
            .attach    (attach_stb[gi]),
            .detach    (detach_stb[gi]),
            .word      (words[gi]),
            .dev_reset (dev_reset_pulse[gi])
        );
        assign port_super_speed[gi] = (gi >= NUM_USB2);
    end

    always_comb begin
        bk_d = bk_q;
        if (bus_rd) begin
            bk_d.rdata = '0;
            if (hit && (int'(idx) < NUM_PORTS)) begin
                bk_d.rdata = words[idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign bus_rdata = bk_q.rdata;

    AST_PR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[B_PR]); // R9

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> (bus_rdata == 32'h0)); // R4

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_reset_pulse != '0) |-> $past(bus_wr)); // R9

endmodule

// File: tb/usbhc_port_bank_tb_top.sv
`timescale 1ns/1ps
module usbhc_port_bank_tb_top;
    localparam int NP  = 4;
    localparam int NU2 = 2;
    localparam int AW  = 12;
    localparam logic [31:0] CHG_MASK = 32'h00FE_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [2:0]    bus_size = 3'd4;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] attach_stb = '0;
    logic [NP-1:0] detach_stb = '0;
    logic [NP-1:0] dev_reset_pulse;
    logic [NP-1:0] port_super_speed;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [NP];

    always #10 clk = ~clk;

    usbhc_port_bank #(.NUM_PORTS(NP), .NUM_USB2(NU2), .ADDR_W(AW)) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_size (bus_size), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .attach_stb (attach_stb), .detach_stb (detach_stb),
        .dev_reset_pulse (dev_reset_pulse), .port_super_speed (port_super_speed)
    );

    function automatic logic [AW-1:0] status_addr(int p);
        return AW'(12'h400 + 16 * p);
    endfunction

    function automatic logic [31:0] after_write(logic [31:0] cur, logic [31:0] d);
        logic [31:0] n;
        n = cur & ~(d & CHG_MASK);
        if (d[4]) n = n | 32'h0020_0002;
        return n;
    endfunction

    function automatic logic [31:0] after_event(logic [31:0] cur, logic att, logic det);
        logic [31:0] n;
        n = cur;
        if (det)      n = (n & ~32'h3) | 32'h0002_0000;
        else if (att) n = n | 32'h0002_0001;
        return n;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [2:0] sz, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_rd = 1'b0; bus_size = 3'd4;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [2:0] sz, input logic [31:0] d,
                      input logic [NP-1:0] exp_pulse, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 3'd4;
        check(dev_reset_pulse == exp_pulse, req, 32'(dev_reset_pulse), 32'(exp_pulse));
        @(negedge clk);
        check(dev_reset_pulse == '0, "R9 pulse one cycle", 32'(dev_reset_pulse), 32'h0);
    endtask

    task automatic strobe(input logic [NP-1:0] att, input logic [NP-1:0] det);
        @(negedge clk);
        attach_stb = att; detach_stb = det;
        @(negedge clk);
        attach_stb = '0; detach_stb = '0;
        for (int p = 0; p < NP; p++) model[p] = after_event(model[p], att[p], det[p]);
    endtask

    task automatic check_all(input string req);
        for (int p = 0; p < NP; p++) rd(status_addr(p), 3'd4, model[p], req);
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fail++;
        $display("FAIL R10 watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int p = 0; p < NP; p++) model[p] = 32'h0000_0200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_all("R1 reset value");
        // R11 static speed flags
        check(port_super_speed == 4'b1100, "R11 speed flags", 32'(port_super_speed), 32'hC);

        // R6 attach on port 1, R2 others untouched
        strobe(4'b0010, 4'b0000);
        check_all("R6 R2 attach port1");
        // R9 reset port 1
        wr(status_addr(1), 3'd4, 32'h0000_0010, 4'b0010, "R9 reset pulse");
        model[1] = after_write(model[1], 32'h10);
        rd(status_addr(1), 3'd4, model[1], "R9 enabled and reset-change, bit4 zero");
        // R8 write 0 to change bits leaves them
        wr(status_addr(1), 3'd4, 32'h0000_0000, 4'b0000, "R8 no pulse");
        rd(status_addr(1), 3'd4, model[1], "R8 write zero keeps");
        // R8 clear connect-change only
        wr(status_addr(1), 3'd4, 32'h0002_0000, 4'b0000, "R8 no pulse");
        model[1] = after_write(model[1], 32'h0002_0000);
        rd(status_addr(1), 3'd4, model[1], "R8 clear connect change");
        // R7 detach
        strobe(4'b0010, 4'b0010);
        rd(status_addr(1), 3'd4, model[1], "R7 detach wins");
        // R7 event after same-cycle clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = status_addr(1); bus_wdata = 32'h0002_0000; attach_stb = 4'b0010;
        @(negedge clk);
        bus_wr = 1'b0; attach_stb = '0;
        model[1] = after_event(after_write(model[1], 32'h0002_0000), 1'b1, 1'b0);
        rd(status_addr(1), 3'd4, model[1], "R7 strobe after write");

        // R3 secondary words and unaligned
        strobe(4'b1111, 4'b0000);
        for (int o = 1; o < 16; o++) begin
            rd(status_addr(2) + AW'(o), 3'd4, 32'h0, "R3 other offset reads zero");
            wr(status_addr(2) + AW'(o), 3'd4, 32'hFFFF_FFFF, 4'b0000, "R3 write ignored no pulse");
        end
        check_all("R3 state untouched");
        // R4 out of range
        rd(status_addr(NP), 3'd4, 32'h0, "R4 past last port");
        wr(status_addr(NP), 3'd4, 32'hFFFF_FFFF, 4'b0000, "R4 write past last ignored");
        rd(12'h3FC, 3'd4, 32'h0, "R4 below base");
        wr(12'h3F0, 3'd4, 32'hFFFF_FFFF, 4'b0000, "R4 write below base ignored");
        check_all("R4 state untouched");
        // R5 sizes
        for (int s = 0; s < 8; s++) begin
            if (s != 4) begin
                rd(status_addr(0), 3'(s), 32'h0, "R5 bad size reads zero");
                wr(status_addr(0), 3'(s), 32'hFFFF_FFFF, 4'b0000, "R5 bad size write ignored");
            end
        end
        check_all("R5 state untouched");

        // R10 read coinciding with write returns old value, then holds
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = status_addr(3); bus_wdata = 32'h00FE_0000;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(bus_rdata == model[3], "R10 read before write", bus_rdata, model[3]);
        model[3] = after_write(model[3], 32'h00FE_0000);
        @(negedge clk);
        check(bus_rdata == after_event(32'h0000_0200, 1'b1, 1'b0), "R10 hold", bus_rdata,
              after_event(32'h0000_0200, 1'b1, 1'b0));
        check_all("R10 R8 after combined access");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            int p;
            logic [31:0] d;
            op = int'($urandom % 4);
            p  = int'($urandom % NP);
            d  = $urandom;
            case (op)
                0: strobe(NP'($urandom), NP'($urandom));
                1: begin
                    wr(status_addr(p), 3'd4, d, d[4] ? NP'(1 << p) : '0, "R9 random pulse");
                    model[p] = after_write(model[p], d);
                end
                2: rd(status_addr(p), 3'd4, model[p], "R2 R8 random read");
                default: rd(status_addr(p) + AW'(4 * (1 + ($urandom % 3))), 3'd4, 32'h0, "R3 random other word");
            endcase
        end
        check_all("R2 final state");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule